// File: doc/BRIEF.md
# Windowed Register Index Mapper

This block turns a logical integer register number, as seen by one instruction, into a physical index into a flat register file. The register file holds several sets of global registers, a circular store of overlapping register windows, and a few scratch registers reserved for microcode. Two small pieces of state steer the translation: a window pointer that selects the active window, and a global level that selects which set of globals is visible.

Three views are computed side by side: the current window, the next window (pointer minus one) and the previous window (pointer plus one). All three share the active global set. A view select picks which one drives the output. The lookup is purely combinational. The window pointer and the global level are registers written through strobes, and each write changes the mapping from the following cycle.

With the default parameters there are 8 globals per set, 4 sets, 8 windows of 16 registers, 24 windowed names per view and 8 microcode registers. The physical file therefore has 32 global, 128 windowed and 8 microcode entries, which is 168 entries in total.

Top module: `wreg_index_mapper`

## Requirements
- R1: After reset the window pointer and the global level are both 0. With the current view selected, logical 5 maps to 5 and logical 8 maps to 32.
- R2: Logical index 0 (global slot 0) maps to physical 0 for every global level, window pointer and view.
- R3: Logical index i, with 1 ≤ i ≤ 7, is global slot i and maps to i + gl × 8.
- R4: Logical index 8 + j, with 0 ≤ j ≤ 23, is windowed slot j. In the current view it maps to 32 + ((j − cwp × 16 + 128) mod 128).
- R5: The next view applies the R4 formula with the window (cwp + 7) mod 8. The previous view applies it with the window (cwp + 1) mod 8.
- R6: The global mapping of R2 and R3 is identical in all three views.
- R7: A window-pointer write with a value of 8 or more stores 7. Smaller values are stored unchanged.
- R8: Logical index 32 + k, with 0 ≤ k ≤ 7, maps to 160 + k, independent of the window pointer, the global level and the view.
- R9: A lookup reflects the state in the same cycle. A pointer or level write changes the mapping only after the clock edge that samples the strobe. Without a strobe, the state holds.
- R10: view_sel encoding is 0 = current, 1 = next, 2 = previous, 3 = current. Logical indices 40 to 63 map to physical 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cwp_we | input | 1 | Window pointer write strobe |
| cwp_wdata | input | 5 | Window pointer write value, clamped to 7 |
| gl_we | input | 1 | Global level write strobe |
| gl_wdata | input | 2 | Global level write value |
| log_idx | input | 6 | Logical register index |
| view_sel | input | 2 | View select (0 current, 1 next, 2 previous, 3 current) |
| phys_idx | output | 8 | Physical register-file index |

## Verification
The lookup has no register in its path, so phys_idx is due in the same cycle as log_idx and view_sel. The bench drives these on the falling edge and samples 1 ns later, with no clock edge in between. Pointer and level writes are due one rising edge after the strobe. The bench checks the old mapping just before that edge and the new mapping just after it. An exhaustive sweep covers every window pointer, global level, view and logical index, and compares each result with values the bench computes arithmetically.

// File: rtl/wrm_pkg.sv
// Shared types for the windowed register index mapper.
// Assumes the view select field is two bits wide; code 3 aliases the current view.
package wrm_pkg;
    typedef enum logic [1:0] {
        VIEW_CUR  = 2'd0,
        VIEW_NEXT = 2'd1,
        VIEW_PREV = 2'd2,
        VIEW_ALT  = 2'd3
    } view_e;
endpackage

// File: rtl/wrm_ptr_regs.sv
// Holds the window pointer and the global level.
// Assumes NWIN >= 2. A pointer write at or above NWIN saturates to NWIN-1.
module wrm_ptr_regs #(
    parameter int NWIN     = 8,
    parameter int NGSETS   = 4,
    parameter int CWP_IN_W = 5,
    localparam int CW      = $clog2(NWIN),
    localparam int GW      = (NGSETS > 1) ? $clog2(NGSETS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cwp_we,
    input  logic [CWP_IN_W-1:0] cwp_wdata,
    input  logic                gl_we,
    input  logic [GW-1:0]       gl_wdata,
    output logic [CW-1:0]       cwp_q,
    output logic [GW-1:0]       gl_q
);
    logic [CW-1:0] cwp_next;

    // Saturate an out-of-range pointer value to the top window.
    always_comb begin
        if (cwp_wdata >= CWP_IN_W'(NWIN)) cwp_next = CW'(NWIN - 1);
        else                              cwp_next = cwp_wdata[CW-1:0];
    end

    // State update: clear on reset, load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q <= '0;
            gl_q  <= '0;
        end else begin
            if (cwp_we) cwp_q <= cwp_next;
            if (gl_we)  gl_q  <= gl_wdata;
        end
    end

    // R7
    cwp_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cwp_we && (cwp_wdata >= CWP_IN_W'(NWIN))) |=> (cwp_q == CW'(NWIN - 1)));
    // R9
    cwp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cwp_we |=> $stable(cwp_q));
    // R9
    gl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gl_we |=> (gl_q == $past(gl_wdata)));
endmodule

// File: rtl/wrm_view_map.sv
// Maps one logical index to a physical index for one view.
// The window is selected as (cwp + OFFSET) mod NWIN.
// Assumes WIN_VIEW <= RPW*NWIN, so the modular window term never goes negative.
module wrm_view_map #(
    parameter int NGLOB    = 8,
    parameter int NGSETS   = 4,
    parameter int NWIN     = 8,
    parameter int RPW      = 16,
    parameter int WIN_VIEW = 24,
    parameter int NMICRO   = 8,
    parameter int OFFSET   = 0,
    localparam int CW      = $clog2(NWIN),
    localparam int GW      = (NGSETS > 1) ? $clog2(NGSETS) : 1,
    localparam int TG      = NGLOB * NGSETS,
    localparam int TW      = NWIN * RPW,
    localparam int LW      = $clog2(NGLOB + WIN_VIEW + NMICRO),
    localparam int PW      = $clog2(TG + TW + NMICRO)
) (
    input  logic [CW-1:0] cwp,
    input  logic [GW-1:0] gl,
    input  logic [LW-1:0] log_idx,
    output logic [PW-1:0] phys
);
    int win;
    int li;
    int res;

    // Classify the logical index and apply the matching region formula.
    always_comb begin
        win = (int'(cwp) + NWIN + OFFSET) % NWIN;
        li  = int'(log_idx);
        if (li < NGLOB) begin
            res = (li == 0) ? 0 : li + int'(gl) * NGLOB;
        end else if (li < NGLOB + WIN_VIEW) begin
            res = TG + (((li - NGLOB) - win * RPW + TW) % TW);
        end else if (li < NGLOB + WIN_VIEW + NMICRO) begin
            res = TG + TW + (li - NGLOB - WIN_VIEW);
        end else begin
            res = 0;
        end
        phys = PW'(res);
    end
endmodule

// File: rtl/wreg_index_mapper.sv
// Top of the windowed register index mapper.
// It computes the current, next and previous views in parallel and selects one.
// Assumes the lookup is used combinationally in the cycle it is presented.
module wreg_index_mapper #(
    parameter int NGLOB    = 8,
    parameter int NGSETS   = 4,
    parameter int NWIN     = 8,
    parameter int RPW      = 16,
    parameter int WIN_VIEW = 24,
    parameter int NMICRO   = 8,
    parameter int CWP_IN_W = 5,
    localparam int CW      = $clog2(NWIN),
    localparam int GW      = (NGSETS > 1) ? $clog2(NGSETS) : 1,
    localparam int TG      = NGLOB * NGSETS,
    localparam int TW      = NWIN * RPW,
    localparam int LW      = $clog2(NGLOB + WIN_VIEW + NMICRO),
    localparam int PW      = $clog2(TG + TW + NMICRO),
    localparam int NVIEW   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cwp_we,
    input  logic [CWP_IN_W-1:0] cwp_wdata,
    input  logic                gl_we,
    input  logic [GW-1:0]       gl_wdata,
    input  logic [LW-1:0]       log_idx,
    input  logic [1:0]          view_sel,
    output logic [PW-1:0]       phys_idx
);
    import wrm_pkg::*;

    logic [CW-1:0] cwp_q;
    logic [GW-1:0] gl_q;
    logic [PW-1:0] view_phys [NVIEW];

    wrm_ptr_regs #(.NWIN(NWIN), .NGSETS(NGSETS), .CWP_IN_W(CWP_IN_W)) i_ptr (
        .clk(clk), .rst_n(rst_n),
        .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
        .gl_we(gl_we), .gl_wdata(gl_wdata),
        .cwp_q(cwp_q), .gl_q(gl_q)
    );

    // View 0 is the current window, view 1 the next (cwp-1), view 2 the previous (cwp+1).
    for (genvar v = 0; v < NVIEW; v++) begin : g_view
        localparam int OFS = (v == 0) ? 0 : ((v == 1) ? -1 : 1);
        wrm_view_map #(
            .NGLOB(NGLOB), .NGSETS(NGSETS), .NWIN(NWIN), .RPW(RPW),
            .WIN_VIEW(WIN_VIEW), .NMICRO(NMICRO), .OFFSET(OFS)
        ) i_map (
            .cwp(cwp_q), .gl(gl_q), .log_idx(log_idx), .phys(view_phys[v])
        );
    end

    // Output select; code 3 falls back to the current view.
    always_comb begin
        case (view_e'(view_sel))
            VIEW_NEXT: phys_idx = view_phys[1];
            VIEW_PREV: phys_idx = view_phys[2];
            default:   phys_idx = view_phys[0];
        endcase
    end

    // R2
    g0_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_idx == '0) |-> (phys_idx == '0));
    // R8
    micro_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(log_idx) >= NGLOB + WIN_VIEW) && (int'(log_idx) < NGLOB + WIN_VIEW + NMICRO))
        |-> (int'(phys_idx) >= TG + TW));
    // R4
    win_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(log_idx) >= NGLOB) && (int'(log_idx) < NGLOB + WIN_VIEW))
        |-> ((int'(phys_idx) >= TG) && (int'(phys_idx) < TG + TW)));
    // R10
    idx_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(log_idx) >= NGLOB + WIN_VIEW + NMICRO) |-> (phys_idx == '0));
endmodule

// File: tb/test_wreg_index_mapper.sv
module test_wreg_index_mapper;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cwp_we = 1'b0;
    logic [4:0] cwp_wdata = '0;
    logic       gl_we = 1'b0;
    logic [1:0] gl_wdata = '0;
    logic [5:0] log_idx = '0;
    logic [1:0] view_sel = '0;
    logic [7:0] phys_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    wreg_index_mapper i_wreg_index_mapper (
        .clk(clk), .rst_n(rst_n), .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
        .gl_we(gl_we), .gl_wdata(gl_wdata), .log_idx(log_idx),
        .view_sel(view_sel), .phys_idx(phys_idx)
    );

    function automatic int model(int c, int g, int v, int i);
        int w;
        w = (v == 1) ? (c + 7) % 8 : ((v == 2) ? (c + 1) % 8 : c);
        if (i == 0) return 0;
        if (i < 8)  return i + g * 8;
        if (i < 32) return 32 + (((i - 8) - w * 16 + 128) % 128);
        if (i < 40) return 160 + (i - 32);
        return 0;
    endfunction

    function automatic string req_of(int v, int i);
        if (i == 0) return "R2";
        if (i < 8)  return (v == 0 || v == 3) ? "R3" : "R6";
        if (i < 32) return (v == 0 || v == 3) ? "R4" : "R5";
        if (i < 40) return "R8";
        return "R10";
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic look(int v, int i, string req, int exp);
        view_sel = 2'(v);
        log_idx  = 6'(i);
        #1;
        chk(req, int'(phys_idx), exp);
    endtask

    task automatic wr_cwp(int val);
        @(negedge clk);
        cwp_we = 1'b1;
        cwp_wdata = 5'(val);
        @(negedge clk);
        cwp_we = 1'b0;
    endtask

    task automatic wr_gl(int val);
        @(negedge clk);
        gl_we = 1'b1;
        gl_wdata = 2'(val);
        @(negedge clk);
        gl_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        look(0, 5, "R1", 5);
        look(0, 8, "R1", 32);
        look(1, 8, "R1", model(0, 0, 1, 8));

        // Exhaustive sweep: R2 R3 R4 R5 R6 R8 R10
        for (int c = 0; c < 8; c++) begin
            wr_cwp(c);
            for (int g = 0; g < 4; g++) begin
                wr_gl(g);
                for (int v = 0; v < 4; v++)
                    for (int i = 0; i < 64; i++)
                        look(v, i, req_of(v, i), model(c, g, v, i));
            end
        end

        // R7 clamp on out-of-range pointer writes
        wr_cwp(2);
        wr_cwp(8);
        look(0, 8, "R7", model(7, 3, 0, 8));
        wr_cwp(2);
        wr_cwp(31);
        look(0, 20, "R7", model(7, 3, 0, 20));
        look(2, 8, "R7", model(7, 3, 2, 8));
        wr_cwp(6);
        look(0, 8, "R7", model(6, 3, 0, 8));

        // R9 write timing: old mapping before the edge, new mapping after it
        @(negedge clk);
        cwp_we = 1'b1;
        cwp_wdata = 5'd3;
        gl_we = 1'b1;
        gl_wdata = 2'd1;
        look(0, 8, "R9", model(6, 3, 0, 8));
        look(0, 4, "R9", model(6, 3, 0, 4));
        @(posedge clk);
        #1;
        cwp_we = 1'b0;
        gl_we = 1'b0;
        look(0, 8, "R9", model(3, 1, 0, 8));
        look(0, 4, "R9", model(3, 1, 0, 4));
        // R9 hold without strobe
        cwp_wdata = 5'd5;
        gl_wdata = 2'd2;
        repeat (2) @(posedge clk);
        #1;
        look(0, 8, "R9", model(3, 1, 0, 8));
        look(0, 4, "R9", model(3, 1, 0, 4));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule